// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block sits next to a small 8-bit processor core and does the interrupt bookkeeping that the core leaves to its surroundings. It catches falling edges on the non-maskable input, applies the core's interrupt-mask bit to the level-sensitive maskable input, and drives one registered request line into the core. It also ranks the pending sources and presents a 16-bit vector address, so that the core can load its new program counter from it.

The block's own synchronous reset is the reset source. After reset the reset vector stays selected until the core completes its first vector fetch. The core raises a vector-fetch strobe for the cycles in which it reads the vector. The controller freezes the vector address for the length of that fetch and drives an active-low vector-pull output. When the strobe falls, the controller retires the source it was serving. A break-instruction indicator steers the vector to the break vector, which by default is the same address as the maskable vector. The break indicator never raises a request.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After the synchronous active-high reset `rst`, `irq_req` is 0, `vec_pull_n` is 1 and `vec_addr` is 16'hFFFC. The reset vector remains selected until a vector fetch completes.
- R2: A non-maskable edge is a clock edge at which `nmi_n` is sampled 0 after being sampled 1 at the previous edge. That edge sets the non-maskable pending flag, and `irq_req` is 1 after the following edge.
- R3: Holding `nmi_n` low creates exactly one pending event. Once that event is serviced, `irq_req` stays 0 while `nmi_n` stays low, provided `irq_n` is high or masked.
- R4: With `irq_n` sampled 0 and `irq_mask` sampled 0 at an edge, `irq_req` is 1 after that edge. With `irq_mask` 1 and nothing non-maskable pending, `irq_req` is 0.
- R5: A pending non-maskable event drives `irq_req` to 1 regardless of `irq_mask`.
- R6: The vector follows a fixed priority: reset (16'hFFFC), then non-maskable (16'hFFFA), then maskable (16'hFFFE).
- R7: With `brk_flag` 1 and neither reset nor non-maskable pending, `vec_addr` is 16'hFFFE and `irq_req` is not raised by `brk_flag`.
- R8: `vec_pull_n` is the inverse of `vec_fetch` delayed by one clock.
- R9: `vec_addr` is captured at the edge where `vec_fetch` is first sampled 1. It is held unchanged through the edge where `vec_fetch` is first sampled 0 again.
- R10: The edge where `vec_fetch` falls completes the fetch and clears the pending flag of the source captured in R9. It leaves any other flag unchanged.
- R11: A new non-maskable edge at the same clock edge that completes a non-maskable fetch leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also the reset interrupt source |
| nmi_n | input | 1 | Non-maskable request, active low, falling-edge sensitive |
| irq_n | input | 1 | Maskable request, active low, level sensitive |
| irq_mask | input | 1 | Core interrupt-mask bit, 1 blocks `irq_n` |
| brk_flag | input | 1 | Core is executing a break instruction |
| vec_fetch | input | 1 | High while the core reads the vector |
| irq_req | output | 1 | Registered interrupt request to the core |
| vec_addr | output | 16 | Vector address for the winning source |
| vec_pull_n | output | 1 | Active-low vector-pull indication |

## Verification
Two events can coincide in the same cycle: a new falling edge on `nmi_n`, and the completion of a fetch that is retiring the previous non-maskable event. A directed sequence first releases `nmi_n` while a fetch is in progress. It then drives `nmi_n` low in exactly the cycle that `vec_fetch` drops. The bench judges that the pending flag survives by expecting `irq_req` to stay 1 and the vector to return to 16'hFFFA. Randomised phases that overlap resets, fetches, mask changes and `nmi_n` toggles are compared cycle by cycle against a model built from the requirements.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [1:0] {
    SRC_IRQ = 2'd0,
    SRC_NMI = 2'd1,
    SRC_RST = 2'd2
  } src_e;
endpackage

// File: rtl/irqv_pending.sv
module irqv_pending
  import irqv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic done,
  input  src_e done_src,
  output logic nmi_pend,
  output logic rst_pend
);
  logic nmi_prev;
  logic nmi_edge;
  logic clr_nmi;
  logic clr_rst;

  assign nmi_edge = nmi_prev & ~nmi_n;
  assign clr_nmi  = done && (done_src == SRC_NMI);
  assign clr_rst  = done && (done_src == SRC_RST);

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev <= 1'b1;
      nmi_pend <= 1'b0;
      rst_pend <= 1'b1;
    end else begin
      nmi_prev <= nmi_n;
      nmi_pend <= nmi_edge | (nmi_pend & ~clr_nmi);
      rst_pend <= rst_pend & ~clr_rst;
    end
  end

  AST_NMI_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
    (nmi_prev && !nmi_n) |=> nmi_pend); // R2
  AST_HELD_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!nmi_pend && !nmi_prev && !nmi_n) |=> !nmi_pend); // R3
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_nmi && nmi_edge) |=> nmi_pend); // R11
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] RST_VEC = 16'hFFFC,
  parameter logic [VEC_W-1:0] NMI_VEC = 16'hFFFA,
  parameter logic [VEC_W-1:0] IRQ_VEC = 16'hFFFE,
  parameter logic [VEC_W-1:0] BRK_VEC = 16'hFFFE
)(
  input  logic clk,
  input  logic rst,
  input  logic rst_pend,
  input  logic nmi_pend,
  input  logic brk_flag,
  output src_e win,
  output logic [VEC_W-1:0] vec
);
  localparam int N_SRC = 3;
  logic [N_SRC-1:0] grant;

  always_comb begin
    grant[2] = rst_pend;
    grant[1] = ~rst_pend & nmi_pend;
    grant[0] = ~rst_pend & ~nmi_pend & brk_flag;
  end

  always_comb begin
    if (grant[2]) begin
      win = SRC_RST;
      vec = RST_VEC;
    end else if (grant[1]) begin
      win = SRC_NMI;
      vec = NMI_VEC;
    end else begin
      win = SRC_IRQ;
      vec = grant[0] ? BRK_VEC : IRQ_VEC;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R6
endmodule

// File: rtl/irqv_fetch.sv
module irqv_fetch
  import irqv_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] RST_VEC = 16'hFFFC
)(
  input  logic clk,
  input  logic rst,
  input  logic vec_fetch,
  input  src_e win,
  input  logic [VEC_W-1:0] vec_in,
  output logic [VEC_W-1:0] vec_addr,
  output logic vec_pull_n,
  output logic done,
  output src_e done_src
);
  logic vf_prev;
  src_e svc;

  always_ff @(posedge clk) begin
    if (rst) begin
      vf_prev    <= 1'b0;
      vec_addr   <= RST_VEC;
      vec_pull_n <= 1'b1;
      svc        <= SRC_RST;
    end else begin
      vf_prev    <= vec_fetch;
      vec_pull_n <= ~vec_fetch;
      if (!vf_prev) vec_addr <= vec_in;
      if (vec_fetch && !vf_prev) svc <= win;
    end
  end

  assign done     = vf_prev & ~vec_fetch;
  assign done_src = svc;

  AST_VEC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    vf_prev |=> $stable(vec_addr)); // R9
  AST_VP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    vec_fetch |=> !vec_pull_n); // R8
  AST_VP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !vec_fetch |=> vec_pull_n); // R8
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] RST_VEC = 16'hFFFC,
  parameter logic [VEC_W-1:0] NMI_VEC = 16'hFFFA,
  parameter logic [VEC_W-1:0] IRQ_VEC = 16'hFFFE,
  parameter logic [VEC_W-1:0] BRK_VEC = 16'hFFFE
)(
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic irq_n,
  input  logic irq_mask,
  input  logic brk_flag,
  input  logic vec_fetch,
  output logic irq_req,
  output logic [VEC_W-1:0] vec_addr,
  output logic vec_pull_n
);
  logic nmi_pend;
  logic rst_pend;
  logic done;
  src_e done_src;
  src_e win;
  logic [VEC_W-1:0] vec_sel;

  irqv_pending u_pend (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .done(done), .done_src(done_src),
    .nmi_pend(nmi_pend), .rst_pend(rst_pend)
  );

  irqv_arbiter #(
    .VEC_W(VEC_W), .RST_VEC(RST_VEC), .NMI_VEC(NMI_VEC),
    .IRQ_VEC(IRQ_VEC), .BRK_VEC(BRK_VEC)
  ) u_arb (
    .clk(clk), .rst(rst), .rst_pend(rst_pend), .nmi_pend(nmi_pend),
    .brk_flag(brk_flag), .win(win), .vec(vec_sel)
  );

  irqv_fetch #(.VEC_W(VEC_W), .RST_VEC(RST_VEC)) u_fetch (
    .clk(clk), .rst(rst), .vec_fetch(vec_fetch), .win(win), .vec_in(vec_sel),
    .vec_addr(vec_addr), .vec_pull_n(vec_pull_n), .done(done), .done_src(done_src)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= nmi_pend | (~irq_n & ~irq_mask);
  end

  AST_MASK_OPEN: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !irq_mask) |=> irq_req); // R4
  AST_NMI_IGNORES_MASK: assert property (@(posedge clk) disable iff (rst)
    nmi_pend |=> irq_req); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (irq_mask && !nmi_pend) |=> !irq_req); // R4
endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, nmi_n = 1'b1, irq_n = 1'b1, irq_mask = 1'b1;
  logic brk_flag = 1'b0, vec_fetch = 1'b0;
  logic irq_req, vec_pull_n;
  logic [15:0] vec_addr;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .irq_n(irq_n), .irq_mask(irq_mask),
    .brk_flag(brk_flag), .vec_fetch(vec_fetch), .irq_req(irq_req),
    .vec_addr(vec_addr), .vec_pull_n(vec_pull_n)
  );

  int n_chk = 0, n_fail = 0;

  // requirement-level model state
  logic m_nprev, m_npend, m_rpend, m_req, m_vp, m_vfprev;
  logic [15:0] m_vec;
  int m_sel; // 0 maskable/break, 1 non-maskable, 2 reset

  function automatic logic [15:0] want_vec(logic rp, logic np);
    if (rp) return 16'hFFFC;
    if (np) return 16'hFFFA;
    return 16'hFFFE;
  endfunction

  function automatic int winner(logic rp, logic np);
    return rp ? 2 : (np ? 1 : 0);
  endfunction

  task automatic model_step();
    logic edge_seen, done_now;
    int w;
    if (rst) begin
      m_nprev = 1; m_npend = 0; m_rpend = 1; m_req = 0;
      m_vec = 16'hFFFC; m_vp = 1; m_vfprev = 0; m_sel = 2;
    end else begin
      edge_seen = m_nprev & ~nmi_n;
      done_now  = m_vfprev & ~vec_fetch;
      w = winner(m_rpend, m_npend);
      m_req = m_npend | (~irq_n & ~irq_mask);
      if (!m_vfprev) m_vec = want_vec(m_rpend, m_npend);
      m_rpend = m_rpend & ~(done_now && m_sel == 2);
      m_npend = edge_seen | (m_npend & ~(done_now && m_sel == 1));
      if (vec_fetch && !m_vfprev) m_sel = w;
      m_vp = ~vec_fetch;
      m_vfprev = vec_fetch;
      m_nprev = nmi_n;
    end
  endtask

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, "irq_req", {15'd0, irq_req}, {15'd0, m_req});
    check(tag, "vec_addr", vec_addr, m_vec);
    check(tag, "vec_pull_n", {15'd0, vec_pull_n}, {15'd0, m_vp});
  endtask

  task automatic fetch(string tag, int len);
    vec_fetch = 1;
    for (int i = 0; i < len; i++) tick(tag);
    vec_fetch = 0;
    tick(tag);
  endtask

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    int flen;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    // R1: reset state
    tick("R1"); tick("R1");
    rst = 0;
    tick("R1");
    check("R1", "reset vector", vec_addr, 16'hFFFC);
    check("R1", "reset req", {15'd0, irq_req}, 16'd0);
    irq_n = 0; irq_mask = 0;
    tick("R1 R6"); // reset still outranks a live maskable request
    check("R6", "reset first", vec_addr, 16'hFFFC);
    irq_n = 1; irq_mask = 1;
    fetch("R10", 2); tick("R10");
    check("R10", "after reset fetch", vec_addr, 16'hFFFE);
    // R4 mask open / closed
    irq_n = 0; irq_mask = 0; tick("R4"); tick("R4");
    check("R4", "unmasked req", {15'd0, irq_req}, 16'd1);
    irq_mask = 1; tick("R4"); tick("R4");
    check("R4", "masked req", {15'd0, irq_req}, 16'd0);
    // R2 R5 non-maskable edge while masked
    nmi_n = 0; tick("R2"); tick("R2 R5"); tick("R5");
    check("R5", "nmi through mask", {15'd0, irq_req}, 16'd1);
    check("R6", "nmi over irq", vec_addr, 16'hFFFA);
    // R9 vector frozen while a break arrives mid-fetch
    vec_fetch = 1; tick("R9 R8");
    check("R8", "vp asserted", {15'd0, vec_pull_n}, 16'd0);
    brk_flag = 1; tick("R9"); tick("R9");
    check("R9", "frozen", vec_addr, 16'hFFFA);
    vec_fetch = 0; tick("R10"); tick("R10"); tick("R3");
    // R3 nmi_n still held low: no new event
    for (int i = 0; i < 6; i++) tick("R3");
    check("R3", "held low quiet", {15'd0, irq_req}, 16'd0);
    // R7 break vector without request
    check("R7", "break vector", vec_addr, 16'hFFFE);
    brk_flag = 0; irq_n = 1;
    // R11 new edge coinciding with completion
    nmi_n = 1; tick("R11"); nmi_n = 0; tick("R11"); tick("R11");
    vec_fetch = 1; tick("R11"); nmi_n = 1; tick("R11");
    vec_fetch = 0; nmi_n = 0; tick("R11");
    tick("R11"); tick("R11");
    check("R11", "pending kept", {15'd0, irq_req}, 16'd1);
    check("R11", "vector back", vec_addr, 16'hFFFA);
    fetch("R10", 2); tick("R10"); tick("R10");
    check("R10", "cleared", {15'd0, irq_req}, 16'd0);
    // constrained random mix
    flen = 0;
    for (int c = 0; c < 4000; c++) begin
      rst      = ($urandom_range(0, 299) == 0);
      irq_mask = ($urandom_range(0, 3) != 0);
      brk_flag = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 7) == 0) nmi_n = ~nmi_n;
      if ($urandom_range(0, 9) == 0) irq_n = ~irq_n;
      if (flen > 0) flen--;
      else if ($urandom_range(0, 11) == 0) flen = $urandom_range(1, 3);
      vec_fetch = (flen > 0);
      tick("R2 R4 R5 R6 R8 R9 R10 R11");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule